// File: doc/BRIEF.md
# H-Bridge Fault Latch and Interrupt Controller

This block sits between the control logic of a four-switch H-bridge and its gate drivers. It takes the four requested gate-drive levels, the four per-switch overcurrent detector lines and an overtemperature comparator line. It passes the drive levels through to the switches only while the bridge is enabled and no fault gating applies.

An overcurrent event sets a sticky short-circuit flag at once. Only the switch whose detector fired is cut, and the cut comes a programmable number of cycles later. An overtemperature event sets its own sticky flag and turns every switch off at once. Both flags are read-only. They clear only when software writes the bridge enable bit low. The same write is the only way to drop a pending interrupt request.

A small register port carries two writable control bits and shows the two flags. A flag that rises while interrupts are enabled raises the request. Enabling interrupts while a flag is already set also raises it.

Top module: `hbridge_guard`

## Requirements
- R1: After a synchronous active-low reset, rd_data is 0, every drive output is 0 and irq_o is 0.
- R2: A cycle with wr_valid high loads wr_data bit 0 into the enable bit and bit 1 into the interrupt-enable bit. rd_data shows enable at bit 0, interrupt-enable at bit 1, the short-circuit flag at bit 2 and the overtemperature flag at bit 3. Written values of bits 2 and 3 are ignored.
- R3: Detector inputs pass through two synchronising flip-flops. A detector change first shows in a flag after the third rising clock edge following the change.
- R4: The short-circuit flag sets when any one of the four overcurrent inputs is seen while enable is set. Detector activity while enable is clear leaves both flags at 0.
- R5: A switch whose overcurrent input was seen is forced off CUT_DELAY clock edges after the edge that set the short-circuit flag. Until then it follows its request. Switches whose detector did not fire keep following their requests.
- R6: The overtemperature flag sets when the synchronised overtemperature input is seen while enabled. All four drive outputs are 0 in the same cycle the flag reads 1.
- R7: With enable clear every drive output is 0. With enable set and no fault gating, drv_o equals drv_req.
- R8: Both flags stay set after their detector drops. Writes that keep enable at 1 leave them set. A write of enable 0 clears both on that edge.
- R9: With interrupt-enable set, a rising edge of either flag raises irq_o one clock edge after the flag sets.
- R10: Setting interrupt-enable while a flag is already set raises irq_o one clock edge after the write.
- R11: Once raised, irq_o stays high until a write clears enable. Clearing only interrupt-enable leaves it high.
- R12: Clearing and then setting enable while a fault input is still present sets the flag again and, with interrupt-enable set, raises a new interrupt request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Register write strobe |
| wr_data | input | 4 | Write data (bit 0 enable, bit 1 interrupt enable) |
| rd_data | output | 4 | Control and status readback |
| oc_det | input | 4 | Per-switch overcurrent detector lines, asynchronous |
| ot_det | input | 1 | Overtemperature comparator, asynchronous |
| drv_req | input | 4 | Requested gate-drive levels |
| drv_o | output | 4 | Gated gate-drive outputs, 1 = switch on |
| irq_o | output | 1 | Pending interrupt request |

## Verification
The first pattern drives several drive-request words with the bridge disabled and then enabled. This separates enable gating from plain pass-through. The second fires single-cycle pulses on each overcurrent line in turn. This tells an OR of all four from a subset, shows that only the affected switch is cut, and pins the cut to the exact edge. A held overtemperature level across a disable and re-enable tells sticky latching from re-arming. Interrupt-enable writes placed before and after a flag sets tell edge-triggered requests from requests raised by enabling.

// File: rtl/hbg_pkg.sv
// Package: shared constants for the H-bridge guard.
// Assumes the register word is at least four bits wide.
package hbg_pkg;
    localparam int CTRL_EN_BIT = 0;   // bridge enable
    localparam int CTRL_IE_BIT = 1;   // interrupt enable
    localparam int STAT_SC_BIT = 2;   // short-circuit flag (read-only)
    localparam int STAT_OT_BIT = 3;   // overtemperature flag (read-only)

    typedef struct packed {
        logic ie;
        logic en;
    } hbg_ctrl_t;
endpackage

// File: rtl/hbg_sync.sv
// Module: hbg_sync
// Two-stage synchroniser for a vector of asynchronous inputs.
// Assumes each bit is independent, so no multi-bit coherence is needed.
module hbg_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    // Purpose: shift the raw inputs through two flip-flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;
endmodule

// File: rtl/hbg_switch_cut.sv
// Module: hbg_switch_cut
// Per-switch overcurrent latch and cut-off delay counter.
// Assumes arm_i is the next-cycle enable; dropping it clears the latch.
// cut_o rises DELAY edges after the edge that latched the detector.
module hbg_switch_cut #(
    parameter int DELAY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic det_i,
    output logic cut_o
);
    localparam int CW = $clog2(DELAY + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(DELAY);

    logic          hit_q;
    logic          hit_nx;
    logic [CW-1:0] cnt_q;

    // Purpose: next state of the per-switch latch.
    always_comb begin
        hit_nx = arm_i & (hit_q | det_i);
    end

    // Purpose: latch the detector and count towards the cut-off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            hit_q <= hit_nx;
            if (!hit_nx) begin
                cnt_q <= '0;
            end else if (hit_q && (cnt_q < CNT_MAX)) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign cut_o = hit_q && (cnt_q == CNT_MAX);

    AST_CUT_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cut_o) |-> $past(hit_q)); // R5
    AST_CNT_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_q |-> (cnt_q == '0)); // R5
endmodule

// File: rtl/hbg_fault_core.sv
// Module: hbg_fault_core
// Control register, sticky fault flags and interrupt request.
// Assumes the detector inputs are already synchronised.
// Clearing enable is the single clear for both flags and the request.
module hbg_fault_core #(
    parameter int N_SW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_valid_i,
    input  hbg_pkg::hbg_ctrl_t wr_ctrl_i,
    input  logic [N_SW-1:0] oc_s_i,
    input  logic            ot_s_i,
    output logic            en_nx_o,
    output hbg_pkg::hbg_ctrl_t ctrl_o,
    output logic            sc_o,
    output logic            ot_o,
    output logic            irq_o
);
    hbg_pkg::hbg_ctrl_t ctrl_q;
    hbg_pkg::hbg_ctrl_t ctrl_nx;
    logic sc_q, ot_q, irq_q;
    logic sc_prev_q, ot_prev_q, ie_prev_q;
    logic irq_event;

    // Purpose: next control word from a write or the held value.
    always_comb begin
        ctrl_nx = wr_valid_i ? wr_ctrl_i : ctrl_q;
    end

    // Purpose: detect a flag rising or interrupt enable rising over a set flag.
    always_comb begin
        irq_event = ctrl_q.ie &
                    ((sc_q & ~sc_prev_q) |
                     (ot_q & ~ot_prev_q) |
                     (~ie_prev_q & (sc_q | ot_q)));
    end

    // Purpose: hold the control word, the sticky flags and the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            sc_q      <= 1'b0;
            ot_q      <= 1'b0;
            irq_q     <= 1'b0;
            sc_prev_q <= 1'b0;
            ot_prev_q <= 1'b0;
            ie_prev_q <= 1'b0;
        end else begin
            ctrl_q    <= ctrl_nx;
            sc_q      <= ctrl_nx.en & (sc_q | (|oc_s_i));
            ot_q      <= ctrl_nx.en & (ot_q | ot_s_i);
            irq_q     <= ctrl_nx.en & (irq_q | irq_event);
            sc_prev_q <= sc_q;
            ot_prev_q <= ot_q;
            ie_prev_q <= ctrl_q.ie;
        end
    end

    assign en_nx_o = ctrl_nx.en;
    assign ctrl_o  = ctrl_q;
    assign sc_o    = sc_q;
    assign ot_o    = ot_q;
    assign irq_o   = irq_q;

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> $past(sc_q | ot_q)); // R9
    AST_FLAG_FALL_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sc_q) || $fell(ot_q)) |-> !ctrl_q.en); // R8
    AST_IRQ_FALL_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_q) |-> !ctrl_q.en); // R11
endmodule

// File: rtl/hbridge_guard.sv
// Module: hbridge_guard (top)
// Fault latch and interrupt controller for a four-switch H-bridge.
// Assumes drv_req comes from the mode/PWM mapping logic, already in
// this clock domain. Detector lines are asynchronous.
module hbridge_guard #(
    parameter int N_SW      = 4,
    parameter int CUT_DELAY = 4,
    parameter int REG_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic [N_SW-1:0]  oc_det,
    input  logic             ot_det,
    input  logic [N_SW-1:0]  drv_req,
    output logic [N_SW-1:0]  drv_o,
    output logic             irq_o
);
    localparam int SYNC_W = N_SW + 1;

    logic [SYNC_W-1:0]  det_s;
    logic [N_SW-1:0]    cut;
    logic               en_nx;
    hbg_pkg::hbg_ctrl_t wr_ctrl;
    hbg_pkg::hbg_ctrl_t ctrl;
    logic               sc_flag, ot_flag;
    logic               unused_wr_hi;

    assign wr_ctrl.en   = wr_data[hbg_pkg::CTRL_EN_BIT];
    assign wr_ctrl.ie   = wr_data[hbg_pkg::CTRL_IE_BIT];
    assign unused_wr_hi = ^wr_data[REG_W-1:2];

    hbg_sync #(.W(SYNC_W)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ot_det, oc_det}),
        .sync_o  (det_s)
    );

    hbg_fault_core #(.N_SW(N_SW)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_valid_i (wr_valid),
        .wr_ctrl_i  (wr_ctrl),
        .oc_s_i     (det_s[N_SW-1:0]),
        .ot_s_i     (det_s[N_SW]),
        .en_nx_o    (en_nx),
        .ctrl_o     (ctrl),
        .sc_o       (sc_flag),
        .ot_o       (ot_flag),
        .irq_o      (irq_o)
    );

    for (genvar i = 0; i < N_SW; i++) begin : g_sw
        hbg_switch_cut #(.DELAY(CUT_DELAY)) u_cut (
            .clk   (clk),
            .rst_n (rst_n),
            .arm_i (en_nx),
            .det_i (det_s[i]),
            .cut_o (cut[i])
        );
    end

    // Purpose: gate the requested drives by enable and the fault state.
    always_comb begin
        drv_o = drv_req & ~cut & {N_SW{ctrl.en & ~ot_flag}};
    end

    // Purpose: assemble the readback word.
    always_comb begin
        rd_data = '0;
        rd_data[hbg_pkg::CTRL_EN_BIT] = ctrl.en;
        rd_data[hbg_pkg::CTRL_IE_BIT] = ctrl.ie;
        rd_data[hbg_pkg::STAT_SC_BIT] = sc_flag;
        rd_data[hbg_pkg::STAT_OT_BIT] = ot_flag;
    end

    AST_OT_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ot_flag |-> (drv_o == '0)); // R6
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.en |-> ((drv_o == '0) && !irq_o && !sc_flag && !ot_flag)); // R7
endmodule

// File: tb/hbridge_guard_bench.sv
module hbridge_guard_bench;
    localparam int N = 4;
    localparam int D = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_valid = 1'b0;
    logic [3:0] wr_data = '0;
    logic [3:0] rd_data;
    logic [3:0] oc_det = '0;
    logic       ot_det = 1'b0;
    logic [3:0] drv_req = '0;
    logic [3:0] drv_o;
    logic       irq_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #4 clk = ~clk;   // 125 MHz

    hbridge_guard #(.N_SW(N), .CUT_DELAY(D), .REG_W(4)) u_hbridge_guard (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .rd_data(rd_data), .oc_det(oc_det), .ot_det(ot_det),
        .drv_req(drv_req), .drv_o(drv_o), .irq_o(irq_o)
    );

    // Reference model state
    bit m_en, m_ie, m_sc, m_ot, m_irq, m_scp, m_otp, m_iep;
    bit [3:0] m_s1, m_s2;
    bit m_ots1, m_ots2;
    bit m_hit[4];
    int m_cnt[4];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_ie = 0; m_sc = 0; m_ot = 0; m_irq = 0;
            m_scp = 0; m_otp = 0; m_iep = 0;
            m_s1 = 0; m_s2 = 0; m_ots1 = 0; m_ots2 = 0;
            for (int i = 0; i < 4; i++) begin m_hit[i] = 0; m_cnt[i] = 0; end
        end else begin
            bit en_n, ie_n, ev, h;
            en_n = wr_valid ? wr_data[0] : m_en;
            ie_n = wr_valid ? wr_data[1] : m_ie;
            ev = m_ie && ((m_sc && !m_scp) || (m_ot && !m_otp) || (!m_iep && (m_sc || m_ot)));
            for (int i = 0; i < 4; i++) begin
                h = en_n && (m_hit[i] || m_s2[i]);
                if (!h) m_cnt[i] = 0;
                else if (m_hit[i] && m_cnt[i] < D) m_cnt[i]++;
                m_hit[i] = h;
            end
            m_irq = en_n && (m_irq || ev);
            m_scp = m_sc; m_otp = m_ot; m_iep = m_ie;
            m_sc = en_n && (m_sc || (m_s2 != 0));
            m_ot = en_n && (m_ot || m_ots2);
            m_en = en_n; m_ie = ie_n;
            m_s2 = m_s1; m_s1 = oc_det; m_ots2 = m_ots1; m_ots1 = ot_det;
        end
    end

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [3:0] e_rd, e_drv;
            e_rd = {m_ot, m_sc, m_ie, m_en};
            for (int i = 0; i < 4; i++)
                e_drv[i] = m_en && !m_ot && drv_req[i] && !(m_hit[i] && m_cnt[i] == D);
            n_checks++;
            if (rd_data !== e_rd) begin
                n_fail++;
                $display("FAIL R2 model rd_data act=%b exp=%b t=%0t", rd_data, e_rd, $time);
            end
            n_checks++;
            if (drv_o !== e_drv) begin
                n_fail++;
                $display("FAIL R5 model drv_o act=%b exp=%b t=%0t", drv_o, e_drv, $time);
            end
            n_checks++;
            if (irq_o !== m_irq) begin
                n_fail++;
                $display("FAIL R9 model irq_o act=%b exp=%b t=%0t", irq_o, m_irq, $time);
            end
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) tick();
    endtask

    task automatic wr(input logic [3:0] d);
        wr_valid = 1'b1; wr_data = d;
        tick();
        wr_valid = 1'b0; wr_data = '0;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        ticks(3);
        rst_n = 1'b1;
        #1;
        chk("R1 rd_data after reset", rd_data, 0);
        chk("R1 drv_o after reset", drv_o, 0);
        chk("R1 irq_o after reset", irq_o, 0);

        // R7: disabled bridge gates everything
        drv_req = 4'b1111; tick();
        chk("R7 disabled drv_o", drv_o, 0);
        wr(4'b0001);
        drv_req = 4'b1001; #1;
        chk("R7 pass-through 1001", drv_o, 4'b1001);
        drv_req = 4'b0110; #1;
        chk("R7 pass-through 0110", drv_o, 4'b0110);

        // R2: flag bits of a write are ignored
        wr(4'b1101);
        chk("R2 readback ignores flag bits", rd_data, 4'b0001);

        // R3/R5: single-cycle pulse on switch 2
        drv_req = 4'b1111;
        oc_det = 4'b0100; tick();
        oc_det = 4'b0000; tick();
        chk("R3 flag not yet set after two edges", rd_data[2], 0);
        tick();
        chk("R3 flag set after third edge", rd_data[2], 1);
        ticks(D - 1);
        chk("R5 switch 2 still driven before delay", drv_o, 4'b1111);
        tick();
        chk("R5 only switch 2 cut after delay", drv_o, 4'b1011);
        chk("R9 no irq with interrupts disabled", irq_o, 0);

        // R10: enabling interrupts over a set flag
        wr(4'b0011);
        chk("R10 irq not before next edge", irq_o, 0);
        tick();
        chk("R10 irq after enabling over flag", irq_o, 1);

        // R11/R8: stickiness
        wr(4'b0001);
        chk("R11 irq held after ie cleared", irq_o, 1);
        wr(4'b0001);
        chk("R8 flag held after enable rewrite", rd_data[2], 1);
        chk("R8 cut held after enable rewrite", drv_o, 4'b1011);
        wr(4'b0000);
        chk("R8 flags cleared by enable low", rd_data, 0);
        chk("R11 irq cleared by enable low", irq_o, 0);

        // R6/R9/R12: held overtemperature
        wr(4'b0011);
        ot_det = 1'b1; ticks(3);
        chk("R6 ot flag set", rd_data[3], 1);
        chk("R6 all drives off", drv_o, 0);
        chk("R9 irq not yet", irq_o, 0);
        tick();
        chk("R9 irq one edge after flag", irq_o, 1);
        wr(4'b0010);
        chk("R12 cleared by disable", {irq_o, rd_data[3]}, 0);
        wr(4'b0011);
        chk("R12 flag sets again", rd_data[3], 1);
        tick();
        chk("R12 new irq", irq_o, 1);
        ot_det = 1'b0;
        wr(4'b0000);
        ticks(3);

        // R4: detectors ignored while disabled
        oc_det = 4'b0001; tick(); oc_det = 0; ticks(4);
        chk("R4 no flag while disabled", rd_data[2], 0);

        // R4: each detector alone sets the flag
        for (int i = 0; i < 4; i++) begin
            wr(4'b0001);
            oc_det = 4'(1 << i); tick(); oc_det = 0; ticks(2);
            chk($sformatf("R4 detector %0d sets flag", i), rd_data[2], 1);
            ticks(D);
            chk($sformatf("R5 detector %0d cuts own switch", i), drv_o, 4'b1111 & ~4'(1 << i));
            wr(4'b0000);
        end
        wr(4'b0001);
        oc_det = 4'b1111; tick(); oc_det = 0; ticks(2 + D);
        chk("R5 all four cut", drv_o, 0);
        wr(4'b0000);
        ticks(2);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule